// File: doc/BRIEF.md
# Audio CPU Address Decoder with Indexed DSP Register Port

This block sits between an 8-bit audio processor and its memory. Every CPU access to the 64 KB address space is sorted into one of four targets. Two fixed addresses form an indirect window onto a DSP register file: one holds an index and the other moves data to or from the register that the index selects. A 64-byte read-only area sits at the top of the map. All other addresses are passed straight through to an external synchronous byte-wide RAM.

The DSP register file has two parts. One is a bank of 15 global bytes. The other is an array of 8 voices with 10 bytes each. Bit 7 of the index chooses the part. Each field of the index is reduced modulo the number of entries it selects among, so an index that is out of range wraps around instead of reaching a register that does not exist.

Every read completes in exactly one cycle. The external RAM returns data one clock after the request. The decoder registers the data for its own targets so that they arrive in the same cycle.

Top module: `audio_reg_decoder`

## Requirements
- R1: While reset is held low, and after reset is released, the index is 0, every global and voice register is 0, and `cpu_rdata_o` reads 0 until the first read completes.
- R2: Address 0x00F2 holds the 8-bit DSP index. A write there stores `cpu_wdata_i`. A read there returns the stored index.
- R3: When index bit 7 is 0, the data port at 0x00F3 reaches global register (index mod 15). A write to the port updates that register and a read returns it. For example, index 20 reaches the same register as index 5.
- R4: When index bit 7 is 1, the data port reaches a voice register. The voice number is (index bits 6:4) mod 8 and the register number is (index bits 3:0) mod 10. Voice registers and global registers are separate storage.
- R5: A write to an address below 0xFFC0, other than 0x00F2 or 0x00F3, raises `ram_we_o` in the same cycle and presents the CPU address and data on the RAM pins. A read to such an address raises `ram_re_o` in the same cycle. `ram_we_o` and `ram_re_o` are never high together.
- R6: Data for a RAM read appears on `cpu_rdata_o` in the cycle after the request. The bench's RAM starts out all zeros.
- R7: A read in the range 0xFFC0 to 0xFFFF returns ((offset << 2) | 3) XOR 0x5A, where offset is address bits 5:0. A write in that range changes nothing.
- R8: Accesses to 0x00F2, to 0x00F3 and to the read-only range never raise either RAM strobe.
- R9: A read is taken when `cpu_re_i` is high and `cpu_we_i` is low. `cpu_rdata_o` holds its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_we_i | input | 1 | CPU write strobe |
| cpu_re_i | input | 1 | CPU read strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | CPU read data, one cycle after the read |
| ram_addr_o | output | 16 | RAM address |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ram_wdata_o | output | 8 | RAM write data |
| ram_rdata_i | input | 8 | RAM read data, valid one cycle after `ram_re_o` |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the index at 0x00F2, the data port at 0x00F3, 8 voices of 10 registers, and 15 global registers. With these values the index can wrap in both the global and the voice space: the global bank is reached at 20 and 29, and voice register 12 folds onto register 2. Because the index is 8 bits wide, the bench also reaches voice 7 register 9 and both ends of the read-only range, and it can show that the RAM byte just below that range is an ordinary RAM location.

// File: rtl/audio_dec_pkg.sv
package audio_dec_pkg;
  typedef enum logic [1:0] {TGT_RAM, TGT_IDX, TGT_PORT, TGT_ROM} tgt_e;

  localparam int ROM_AW   = 6;
  localparam int VSEL_BIT = 7;

  function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] off);
    return {off, 2'b11} ^ 8'h5A;
  endfunction
endpackage

// File: rtl/adec_addr_map.sv
module adec_addr_map import audio_dec_pkg::*; #(
  parameter int              ADDR_W    = 16,
  parameter logic [15:0]     IDX_ADDR  = 16'h00F2,
  parameter logic [15:0]     PORT_ADDR = 16'h00F3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_e              tgt_o
);
  always_comb begin
    if (&addr_i[ADDR_W-1:ROM_AW])          tgt_o = TGT_ROM;
    else if (addr_i == ADDR_W'(IDX_ADDR))  tgt_o = TGT_IDX;
    else if (addr_i == ADDR_W'(PORT_ADDR)) tgt_o = TGT_PORT;
    else                                   tgt_o = TGT_RAM;
  end
endmodule

// File: rtl/adec_dsp_regs.sv
module adec_dsp_regs import audio_dec_pkg::*; #(
  parameter int DATA_W  = 8,
  parameter int N_VOICE = 8,
  parameter int N_VREG  = 10,
  parameter int N_GREG  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idx_we_i,
  input  logic              port_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [7:0]        idx_o,
  output logic [DATA_W-1:0] port_rdata_o
);
  localparam int VW = (N_VOICE > 1) ? $clog2(N_VOICE) : 1;
  localparam int RW = (N_VREG  > 1) ? $clog2(N_VREG)  : 1;
  localparam int GW = (N_GREG  > 1) ? $clog2(N_GREG)  : 1;

  logic [7:0]        idx_q;
  logic [DATA_W-1:0] greg_q [N_GREG];
  logic [DATA_W-1:0] vreg_q [N_VOICE][N_VREG];
  logic [VW-1:0]     vnum;
  logic [RW-1:0]     rnum;
  logic [GW-1:0]     gnum;
  logic              vsel;

  // modulo fold of each index field
  assign vsel = idx_q[VSEL_BIT];
  assign vnum = VW'(32'(idx_q[6:4]) % 32'(N_VOICE));
  assign rnum = RW'(32'(idx_q[3:0]) % 32'(N_VREG));
  assign gnum = GW'(32'(idx_q[6:0]) % 32'(N_GREG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_we_i) idx_q <= wdata_i[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < N_GREG; g++) greg_q[g] <= '0;
      for (int v = 0; v < N_VOICE; v++)
        for (int r = 0; r < N_VREG; r++) vreg_q[v][r] <= '0;
    end else if (port_we_i) begin
      if (vsel) vreg_q[vnum][rnum] <= wdata_i;
      else      greg_q[gnum]       <= wdata_i;
    end
  end

  assign idx_o        = idx_q;
  assign port_rdata_o = vsel ? vreg_q[vnum][rnum] : greg_q[gnum];
endmodule

// File: rtl/adec_rd_align.sv
module adec_rd_align #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_local_i,
  input  logic              rd_ram_i,
  input  logic [DATA_W-1:0] local_data_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic              from_ram_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      from_ram_q <= 1'b0;
      data_q     <= '0;
    end else if (rd_ram_i) begin
      from_ram_q <= 1'b1;
    end else if (rd_local_i) begin
      from_ram_q <= 1'b0;
      data_q     <= local_data_i;
    end
  end

  // RAM data is held by the RAM until its next read
  assign rdata_o = from_ram_q ? ram_rdata_i : data_q;
endmodule

// File: rtl/audio_reg_decoder.sv
module audio_reg_decoder import audio_dec_pkg::*; #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] IDX_ADDR  = 16'h00F2,
  parameter logic [15:0] PORT_ADDR = 16'h00F3,
  parameter int          N_VOICE   = 8,
  parameter int          N_VREG    = 10,
  parameter int          N_GREG    = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic              cpu_re_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_we_o,
  output logic              ram_re_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  input  logic [DATA_W-1:0] ram_rdata_i
);
  tgt_e              tgt;
  logic              rd;
  logic [7:0]        idx;
  logic [DATA_W-1:0] port_rdata;
  logic [DATA_W-1:0] local_data;

  adec_addr_map #(.ADDR_W(ADDR_W), .IDX_ADDR(IDX_ADDR), .PORT_ADDR(PORT_ADDR)) u_map (
    .addr_i (cpu_addr_i),
    .tgt_o  (tgt)
  );

  adec_dsp_regs #(.DATA_W(DATA_W), .N_VOICE(N_VOICE), .N_VREG(N_VREG), .N_GREG(N_GREG)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .idx_we_i     (cpu_we_i && tgt == TGT_IDX),
    .port_we_i    (cpu_we_i && tgt == TGT_PORT),
    .wdata_i      (cpu_wdata_i),
    .idx_o        (idx),
    .port_rdata_o (port_rdata)
  );

  assign rd = cpu_re_i && !cpu_we_i;

  always_comb begin
    unique case (tgt)
      TGT_IDX:  local_data = DATA_W'(idx);
      TGT_PORT: local_data = port_rdata;
      TGT_ROM:  local_data = DATA_W'(rom_byte(cpu_addr_i[ROM_AW-1:0]));
      default:  local_data = '0;
    endcase
  end

  adec_rd_align #(.DATA_W(DATA_W)) u_align (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_local_i   (rd && tgt != TGT_RAM),
    .rd_ram_i     (rd && tgt == TGT_RAM),
    .local_data_i (local_data),
    .ram_rdata_i  (ram_rdata_i),
    .rdata_o      (cpu_rdata_o)
  );

  assign ram_addr_o  = cpu_addr_i;
  assign ram_wdata_o = cpu_wdata_i;
  assign ram_we_o    = cpu_we_i && tgt == TGT_RAM;
  assign ram_re_o    = rd && tgt == TGT_RAM;
endmodule

// File: rtl/audio_reg_decoder_chk.sv
module audio_reg_decoder_chk import audio_dec_pkg::*; #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter logic [15:0] IDX_ADDR  = 16'h00F2,
  parameter logic [15:0] PORT_ADDR = 16'h00F3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_we_i,
  input logic              cpu_re_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic [ADDR_W-1:0] ram_addr_o,
  input logic              ram_we_o,
  input logic              ram_re_o,
  input logic [DATA_W-1:0] ram_wdata_o,
  input logic [DATA_W-1:0] ram_rdata_i
);
  logic in_rom, is_reg, plain;
  assign in_rom = &cpu_addr_i[ADDR_W-1:ROM_AW];
  assign is_reg = cpu_addr_i == ADDR_W'(IDX_ADDR) || cpu_addr_i == ADDR_W'(PORT_ADDR);
  assign plain  = !in_rom && !is_reg;

  // R1
  always @(posedge clk_i) if (!rst_ni) rst_rdata_chk: assert (cpu_rdata_o == '0);

  // R5
  ram_wr_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && plain |-> ram_we_o && ram_addr_o == cpu_addr_i && ram_wdata_o == cpu_wdata_i);

  // R5
  ram_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ram_re_o));

  // R8
  no_ram_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !plain |-> !ram_we_o && !ram_re_o);

  // R6
  ram_rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_re_i && !cpu_we_i && plain |=> cpu_rdata_o == ram_rdata_i);

  // R7
  rom_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_re_i && !cpu_we_i && in_rom |=> cpu_rdata_o == DATA_W'(rom_byte($past(cpu_addr_i[ROM_AW-1:0]))));
endmodule

bind audio_reg_decoder audio_reg_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_ADDR(IDX_ADDR), .PORT_ADDR(PORT_ADDR)
) chk_i (.*);

// File: tb/audio_reg_decoder_tb_top.sv
module audio_reg_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_we = 1'b0, cpu_re = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [15:0] ram_addr;
  logic        ram_we, ram_re;
  logic [7:0]  ram_wdata;
  logic [7:0]  ram_q = '0;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  audio_reg_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .cpu_we_i(cpu_we), .cpu_re_i(cpu_re),
    .cpu_wdata_i(cpu_wdata), .cpu_rdata_o(cpu_rdata), .ram_addr_o(ram_addr), .ram_we_o(ram_we),
    .ram_re_o(ram_re), .ram_wdata_o(ram_wdata), .ram_rdata_i(ram_q)
  );

  // environment RAM, zero by default
  logic [7:0] ram_mem [int];
  always @(posedge clk) begin
    if (ram_we) ram_mem[int'(ram_addr)] = ram_wdata;
    if (ram_re) ram_q <= ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 8'h00;
  end

  // reference model
  int         m_idx;
  int         m_g [15];
  int         m_v [8][10];
  int         m_mem [int];
  int         m_rd;

  function automatic int port_val();
    if (m_idx >= 128) return m_v[(m_idx / 16) % 8][(m_idx % 16) % 10];
    return m_g[m_idx % 15];
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic op(bit we, bit re, int addr, int wd, string tag);
    bit plain, rd;
    @(negedge clk);
    cpu_we = we; cpu_re = re; cpu_addr = 16'(addr); cpu_wdata = 8'(wd);
    plain = addr < 'hFFC0 && addr != 'hF2 && addr != 'hF3;
    rd = re && !we;
    #1;
    check(plain ? "R5" : "R8", int'(ram_we), int'(we && plain));
    check(plain ? "R5" : "R8", int'(ram_re), int'(rd && plain));
    if (plain && (we || rd)) check("R5", int'(ram_addr), addr);
    if (plain && we) check("R5", int'(ram_wdata), wd);
    // model update
    if (rd) begin
      if (addr == 'hF2) m_rd = m_idx;
      else if (addr == 'hF3) m_rd = port_val();
      else if (addr >= 'hFFC0) m_rd = (((addr - 'hFFC0) * 4 + 3) ^ 'h5A) & 'hFF;
      else m_rd = m_mem.exists(addr) ? m_mem[addr] : 0;
    end else if (we) begin
      if (addr == 'hF2) m_idx = wd;
      else if (addr == 'hF3) begin
        if (m_idx >= 128) m_v[(m_idx / 16) % 8][(m_idx % 16) % 10] = wd;
        else m_g[m_idx % 15] = wd;
      end else if (addr < 'hFFC0) m_mem[addr] = wd;
    end
    @(posedge clk);
    #1;
    cpu_we = 0; cpu_re = 0;
    check(tag, int'(cpu_rdata), m_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_idx = 0; m_rd = 0;
    foreach (m_g[i]) m_g[i] = 0;
    foreach (m_v[i, j]) m_v[i][j] = 0;
    repeat (3) @(negedge clk);
    check("R1", int'(cpu_rdata), 0);
    rst_n = 1'b1;
    op(0, 1, 'hF2, 0, "R1");            // index clear
    op(0, 1, 'hF3, 0, "R1");            // global 0 clear
    op(1, 0, 'hF2, 'h85, "R1");
    op(0, 1, 'hF3, 0, "R1");            // voice 0 reg 5 clear
    // R2 index read/write
    op(1, 0, 'hF2, 5, "R2");
    op(0, 1, 'hF2, 0, "R2");
    // R3 global bank and wrap
    op(1, 0, 'hF3, 'hAB, "R3");
    op(1, 0, 'hF2, 20, "R3");
    op(0, 1, 'hF3, 0, "R3");
    op(1, 0, 'hF2, 14, "R3");
    op(1, 1, 'hF3, 'h11, "R9");         // write wins, output holds
    op(1, 0, 'hF2, 29, "R3");
    op(0, 1, 'hF3, 0, "R3");
    op(1, 0, 'hF2, 0, "R3");
    op(0, 1, 'hF3, 0, "R3");
    // R4 voice space
    op(1, 0, 'hF2, 'hB2, "R4");
    op(1, 0, 'hF3, 'h77, "R4");
    op(1, 0, 'hF2, 'hBC, "R4");
    op(0, 1, 'hF3, 0, "R4");
    op(1, 0, 'hF2, 'hF9, "R4");
    op(1, 0, 'hF3, 'h9C, "R4");
    op(0, 1, 'hF3, 0, "R4");
    op(1, 0, 'hF2, 'h32, "R4");         // global 50%15=5 untouched
    op(0, 1, 'hF3, 0, "R4");
    op(1, 0, 'hF2, 'h85, "R4");
    op(0, 1, 'hF3, 0, "R4");
    // R5/R6 RAM path
    op(0, 1, 'h0000, 0, "R6");
    op(1, 0, 'h1234, 'h42, "R5");
    op(0, 1, 'h1234, 0, "R6");
    op(1, 0, 'hFFBF, 'h33, "R5");
    op(1, 0, 'h00F1, 'h5E, "R5");
    op(0, 1, 'h00F1, 0, "R6");
    op(0, 0, 'h1234, 0, "R9");          // idle, held
    // R7 read-only range
    op(0, 1, 'hFFC0, 0, "R7");
    op(0, 1, 'hFFFF, 0, "R7");
    op(0, 1, 'hFFD3, 0, "R7");
    op(1, 0, 'hFFC5, 'h00, "R7");
    op(0, 1, 'hFFC5, 0, "R7");
    op(0, 1, 'hFFBF, 0, "R6");
    op(0, 1, 'h1234, 0, "R6");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule